// File: doc/BRIEF.md
# Device Interrupt Enable and Status Unit

This unit is the interrupt register group of a command coprocessor's host interface. The core raises four kinds of one-cycle event pulses: response data ready, status settled, change of owning locality, and ready for a new command. Each pulse is recorded in a sticky status register, whatever its enable bit holds. The host clears status bits by writing ones to them. An enable register chooses which recorded events may raise the interrupt line. A global gate bit in that register can silence the line while every recorded event is kept.

The host reaches the registers through a plain single-cycle register port. Writes take effect at the clock edge. Read data is a combinational function of the address and the current register contents. Besides the enable and status registers, the unit holds an 8-bit line-number register that the host writes and reads back. It also has a read-only capability word. This word shows which events exist, which output sense the instance was built with, and whether the burst count is static. A parameter fixes the output sense to one of four styles: active-high level, active-low level, rising pulse or falling pulse.

Top module: `evt_irq_unit`

## Requirements
- R1: After a synchronous active-low reset, the enable, status and line-number registers read 0, and the interrupt output sits at its idle level. The idle level is 0 for active-high level and rising pulse, and 1 for active-low level and falling pulse.
- R2: An event pulse sets its status bit at the next clock edge, whatever the enable bits hold. Data ready maps to bit 0, status settled to bit 1, locality change to bit 2 and command ready to bit 7. The status register is at offset 0x010.
- R3: A write to offset 0x010 clears each status bit written as 1 and leaves each bit written as 0 unchanged.
- R4: When an event pulse and a write-1 clear hit the same status bit in the same cycle, the bit ends up set.
- R5: The enable register at offset 0x008 stores bits 0, 1, 2, 7 and 31 as written. All its other bits read 0.
- R6: While enable bit 31 (global gate) is 0, the interrupt output stays at its idle level, and the recorded status is kept.
- R7: In the level styles, the output is active exactly while the global gate is 1 and some status bit is set whose enable bit is also set. A set status bit whose enable is 0 does not raise the output.
- R8: In the pulse styles, the output is active for exactly one cycle each time the gated, enabled status goes from none set to some set. It stays idle while that condition holds.
- R9: The line-number register at offset 0x00C stores the low 8 bits of a write and reads them back, with bits 31:8 read as 0.
- R10: The capability word at offset 0x014 reads bits 0, 1, 2 and 7 as 1. It sets exactly one sense bit: bit 3 for active-high level, bit 4 for active-low level, bit 5 for rising pulse, bit 6 for falling pulse. Bit 8 equals the static-burst parameter, and all other bits are 0. Writes to this word change nothing.
- R11: Reads of any other offset return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| ev_data_avail | input | 1 | Event pulse: response data ready |
| ev_sts_valid | input | 1 | Event pulse: status settled |
| ev_loc_change | input | 1 | Event pulse: owning locality changed |
| ev_cmd_ready | input | 1 | Event pulse: ready for a command |
| irq_out | output | 1 | Interrupt line in the configured sense style |

## Verification
The embedded properties check several things on every cycle. They check the per-bit status rules: events set bits, write-1 clears them, and a set wins over a clear in the same cycle. They check the line-number capture, that the output is forced idle while the global gate is off, and that the output follows the level condition. In the pulse styles they also check that no pulse lasts longer than one cycle. The bench's scenarios are needed for the rest. These cover the reset values and the masking of enable bits that cannot be stored. They cover a disabled event that must not raise the line, and a new pulse after the gate is turned back on. They also cover the capability word for each sense style, and that writes to read-only or unmapped offsets are ignored. The bench runs four instances side by side, one per sense style, against a single behavioural model.

// File: rtl/evt_irq_pkg.sv
// Package: shared constants, sense-style type and bit-placement helpers for
// the interrupt enable/status unit. Assumes a 12-bit register page offset.
package evt_irq_pkg;

    // Output sense style chosen per instance.
    typedef enum logic [1:0] {
        SENSE_LVL_HI = 2'd0,
        SENSE_LVL_LO = 2'd1,
        SENSE_RISE   = 2'd2,
        SENSE_FALL   = 2'd3
    } sense_e;

    localparam int NUM_EV        = 4;
    localparam int WORD_W        = 32;
    localparam int GATE_BIT      = 31;
    localparam int BURST_CAP_BIT = 8;
    localparam int SENSE_CAP_LSB = 3;

    localparam logic [11:0] OFS_ENABLE = 12'h008;
    localparam logic [11:0] OFS_VECTOR = 12'h00C;
    localparam logic [11:0] OFS_STATUS = 12'h010;
    localparam logic [11:0] OFS_CAPS   = 12'h014;

    // Word bit position of compact event index k.
    function automatic int ev_pos(input int k);
        case (k)
            0:       return 0;
            1:       return 1;
            2:       return 2;
            default: return 7;
        endcase
    endfunction

    // Word with a 1 at every event bit position.
    function automatic logic [WORD_W-1:0] ev_word_mask();
        logic [WORD_W-1:0] m;
        m = '0;
        for (int k = 0; k < NUM_EV; k++) m[ev_pos(k)] = 1'b1;
        return m;
    endfunction

    // Idle level of the output for a given sense style.
    function automatic logic sense_idle(input sense_e s);
        return (s == SENSE_LVL_LO) || (s == SENSE_FALL);
    endfunction

    // Whether a sense style produces pulses rather than levels.
    function automatic logic sense_is_edge(input sense_e s);
        return (s == SENSE_RISE) || (s == SENSE_FALL);
    endfunction

endpackage

// File: rtl/evt_irq_ctrl.sv
// Module: enable and line-number registers.
// Holds per-event enables, the global gate and the 8-bit line number.
// Assumes the write selects are already decoded and mutually exclusive.
module evt_irq_ctrl
    import evt_irq_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                en_wr_i,
    input  logic                vec_wr_i,
    input  logic [WORD_W-1:0]   wdata_i,
    output logic [NUM_EV-1:0]   ev_en_o,
    output logic                gate_o,
    output logic [VEC_W-1:0]    vec_o,
    output logic [WORD_W-1:0]   en_word_o
);

    logic [NUM_EV-1:0] ev_en_q;
    logic              gate_q;
    logic [VEC_W-1:0]  vec_q;
    logic              unused_wbits;

    assign unused_wbits = ^wdata_i;

    // Enable bits and gate: load on an enable-register write.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ev_en_q <= '0;
            gate_q  <= 1'b0;
        end else if (en_wr_i) begin
            for (int k = 0; k < NUM_EV; k++) ev_en_q[k] <= wdata_i[ev_pos(k)];
            gate_q <= wdata_i[GATE_BIT];
        end
    end

    // Line number: load low bits on a vector-register write.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)       vec_q <= '0;
        else if (vec_wr_i) vec_q <= wdata_i[VEC_W-1:0];
    end

    // Readback word: stored bits at their positions, others zero.
    always_comb begin
        en_word_o = '0;
        for (int k = 0; k < NUM_EV; k++) en_word_o[ev_pos(k)] = ev_en_q[k];
        en_word_o[GATE_BIT] = gate_q;
    end

    assign ev_en_o = ev_en_q;
    assign gate_o  = gate_q;
    assign vec_o   = vec_q;

    p_vec_load_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vec_wr_i |=> (vec_q == $past(wdata_i[VEC_W-1:0])));

    p_en_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_wr_i |=> ($stable(ev_en_q) && $stable(gate_q)));

endmodule

// File: rtl/evt_irq_status.sv
// Module: sticky event status with write-one-to-clear.
// Event pulses set bits regardless of enables; a set beats a same-cycle clear.
// Assumes events are single-cycle pulses aligned to clk_i.
module evt_irq_status
    import evt_irq_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [NUM_EV-1:0]   ev_i,
    input  logic                clr_wr_i,
    input  logic [WORD_W-1:0]   wdata_i,
    output logic [NUM_EV-1:0]   st_o,
    output logic [WORD_W-1:0]   st_word_o
);

    logic [NUM_EV-1:0] st_q;
    logic [NUM_EV-1:0] clr_mask;
    logic              unused_wbits;

    assign unused_wbits = ^wdata_i;

    // Gather the clear request of each event bit from its word position.
    for (genvar k = 0; k < NUM_EV; k++) begin : g_clr
        assign clr_mask[k] = clr_wr_i & wdata_i[ev_pos(k)];
    end

    // Status update: clear requested bits, then set on event.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= (st_q & ~clr_mask) | ev_i;
    end

    // Readback word with status bits at their event positions.
    always_comb begin
        st_word_o = '0;
        for (int k = 0; k < NUM_EV; k++) st_word_o[ev_pos(k)] = st_q[k];
    end

    assign st_o = st_q;

    p_ev_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|ev_i) |=> ((st_q & $past(ev_i)) == $past(ev_i)));

    p_w1c_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|(clr_mask & ~ev_i)) |=> ((st_q & $past(clr_mask & ~ev_i)) == '0));

    p_set_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|(clr_mask & ev_i)) |=> ((st_q & $past(clr_mask & ev_i)) == $past(clr_mask & ev_i)));

    p_idle_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clr_wr_i && ev_i == '0) |=> $stable(st_q));

endmodule

// File: rtl/evt_irq_sense.sv
// Module: output shaping for the interrupt line.
// Turns the gated "any pending" condition into a level or a one-cycle pulse
// of the polarity chosen by SENSE. Assumes any_i comes from registers.
module evt_irq_sense
    import evt_irq_pkg::*;
#(
    parameter sense_e SENSE = SENSE_LVL_HI
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic any_i,
    output logic irq_o
);

    localparam logic IDLE = sense_idle(SENSE);

    if (sense_is_edge(SENSE)) begin : g_edge
        logic prev_q;
        logic pulse;

        // Remember the previous condition to detect its rising transition.
        always_ff @(posedge clk_i) begin
            if (!rst_ni) prev_q <= 1'b0;
            else         prev_q <= any_i;
        end

        assign pulse = any_i & ~prev_q;
        assign irq_o = pulse ^ IDLE;

        p_one_shot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (irq_o != IDLE) |=> (irq_o == IDLE));
    end else begin : g_level
        logic unused_lvl;
        assign unused_lvl = clk_i ^ rst_ni;
        assign irq_o = any_i ^ IDLE;
    end

endmodule

// File: rtl/evt_irq_unit.sv
// Module: top of the interrupt enable/status unit.
// Decodes the register port, gathers event pulses, combines status with
// enables and the gate, and drives the shaped interrupt line.
// Assumes single-cycle writes and combinational reads with no side effects.
module evt_irq_unit
    import evt_irq_pkg::*;
#(
    parameter int     ADDR_W       = 12,
    parameter int     VEC_W        = 8,
    parameter sense_e SENSE        = SENSE_LVL_HI,
    parameter bit     BURST_STATIC = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              ev_data_avail,
    input  logic              ev_sts_valid,
    input  logic              ev_loc_change,
    input  logic              ev_cmd_ready,
    output logic              irq_out
);

    localparam logic IDLE = sense_idle(SENSE);
    localparam logic [WORD_W-1:0] CAPS_WORD =
        ev_word_mask()
        | (WORD_W'(1) << (SENSE_CAP_LSB + int'(SENSE)))
        | (WORD_W'(BURST_STATIC) << BURST_CAP_BIT);

    logic              hit_en, hit_vec, hit_st, hit_caps;
    logic [NUM_EV-1:0] ev_vec, ev_en, st;
    logic              gate, any_pend;
    logic [VEC_W-1:0]  vec;
    logic [WORD_W-1:0] en_word, st_word;

    // Address decode of the four mapped offsets.
    assign hit_en   = (bus_addr == ADDR_W'(OFS_ENABLE));
    assign hit_vec  = (bus_addr == ADDR_W'(OFS_VECTOR));
    assign hit_st   = (bus_addr == ADDR_W'(OFS_STATUS));
    assign hit_caps = (bus_addr == ADDR_W'(OFS_CAPS));

    assign ev_vec = {ev_cmd_ready, ev_loc_change, ev_sts_valid, ev_data_avail};

    evt_irq_ctrl #(.VEC_W(VEC_W)) u_ctrl (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .en_wr_i   (bus_wr & hit_en),
        .vec_wr_i  (bus_wr & hit_vec),
        .wdata_i   (bus_wdata),
        .ev_en_o   (ev_en),
        .gate_o    (gate),
        .vec_o     (vec),
        .en_word_o (en_word)
    );

    evt_irq_status u_status (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .ev_i      (ev_vec),
        .clr_wr_i  (bus_wr & hit_st),
        .wdata_i   (bus_wdata),
        .st_o      (st),
        .st_word_o (st_word)
    );

    // Pending condition: gate on and some enabled status bit set.
    assign any_pend = gate & |(st & ev_en);

    evt_irq_sense #(.SENSE(SENSE)) u_sense (
        .clk_i  (clk),
        .rst_ni (rst_n),
        .any_i  (any_pend),
        .irq_o  (irq_out)
    );

    // Read mux: one register per mapped offset, zero elsewhere.
    always_comb begin
        bus_rdata = '0;
        if (hit_en)   bus_rdata = en_word;
        if (hit_vec)  bus_rdata = WORD_W'(vec);
        if (hit_st)   bus_rdata = st_word;
        if (hit_caps) bus_rdata = CAPS_WORD;
    end

    p_gate_masks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !gate |-> (irq_out == IDLE));

    if (!sense_is_edge(SENSE)) begin : g_lvl_chk
        p_level_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (gate && (st & ev_en) != '0) |-> (irq_out != IDLE));
    end

endmodule

// File: tb/evt_irq_unit_bench.sv
// Bench: four instances (one per sense style) driven in parallel and
// compared every cycle with a behavioural model of the registers.
module evt_irq_unit_bench;
    import evt_irq_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] addr = '0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [3:0]  ev = '0;
    logic [31:0] rdata [4];
    logic        irq   [4];

    int total = 0;
    int bad = 0;
    bit done = 0;

    // Model state.
    int unsigned m_en = 0, m_st = 0, m_vec = 0;
    bit m_prev = 0;
    bit burst [4] = '{1'b1, 1'b0, 1'b1, 1'b0};

    always #10 clk = ~clk;

    evt_irq_unit #(.SENSE(SENSE_LVL_HI), .BURST_STATIC(1'b1)) u_evt_irq_unit (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
        .bus_rdata(rdata[0]), .ev_data_avail(ev[0]), .ev_sts_valid(ev[1]),
        .ev_loc_change(ev[2]), .ev_cmd_ready(ev[3]), .irq_out(irq[0]));
    evt_irq_unit #(.SENSE(SENSE_LVL_LO), .BURST_STATIC(1'b0)) u_evt_irq_unit_lo (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
        .bus_rdata(rdata[1]), .ev_data_avail(ev[0]), .ev_sts_valid(ev[1]),
        .ev_loc_change(ev[2]), .ev_cmd_ready(ev[3]), .irq_out(irq[1]));
    evt_irq_unit #(.SENSE(SENSE_RISE), .BURST_STATIC(1'b1)) u_evt_irq_unit_rise (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
        .bus_rdata(rdata[2]), .ev_data_avail(ev[0]), .ev_sts_valid(ev[1]),
        .ev_loc_change(ev[2]), .ev_cmd_ready(ev[3]), .irq_out(irq[2]));
    evt_irq_unit #(.SENSE(SENSE_FALL), .BURST_STATIC(1'b0)) u_evt_irq_unit_fall (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
        .bus_rdata(rdata[3]), .ev_data_avail(ev[0]), .ev_sts_valid(ev[1]),
        .ev_loc_change(ev[2]), .ev_cmd_ready(ev[3]), .irq_out(irq[3]));

    function automatic int unsigned ev_to_word(input logic [3:0] e);
        return (e[0] ? 32'h1 : 0) | (e[1] ? 32'h2 : 0) | (e[2] ? 32'h4 : 0) | (e[3] ? 32'h80 : 0);
    endfunction

    function automatic bit model_any();
        return m_en[31] && ((m_st & m_en & 32'h87) != 0);
    endfunction

    function automatic logic exp_irq(input int m);
        bit a = model_any();
        case (m)
            0: return a;
            1: return !a;
            2: return a && !m_prev;
            default: return !(a && !m_prev);
        endcase
    endfunction

    function automatic logic [31:0] exp_rd(input int m, input logic [11:0] a);
        case (a)
            12'h008: return m_en;
            12'h00C: return m_vec;
            12'h010: return m_st;
            12'h014: return 32'h87 | (32'h1 << (3 + m)) | (burst[m] ? 32'h100 : 32'h0);
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act,
                         input logic [31:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    task automatic compare_all(input string req);
        for (int m = 0; m < 4; m++) begin
            check(req, $sformatf("irq style %0d", m), 32'(irq[m]), 32'(exp_irq(m)));
            check(req, $sformatf("rdata style %0d @%h", m, addr), rdata[m], exp_rd(m, addr));
        end
    endtask

    // One bus cycle: drive at the falling edge, update the model at the
    // rising edge, compare at the next falling edge.
    task automatic cyc(input logic [11:0] a, input logic w, input logic [31:0] d,
                       input logic [3:0] e, input string req);
        bit old_any;
        addr = a; wr = w; wdata = d; ev = e;
        @(posedge clk);
        old_any = model_any();
        if (w && a == 12'h008) m_en = d & 32'h8000_0087;
        if (w && a == 12'h00C) m_vec = d & 32'hFF;
        m_st = ((m_st & ~((w && a == 12'h010) ? d : 32'h0)) | ev_to_word(e)) & 32'h87;
        m_prev = old_any;
        @(negedge clk);
        compare_all(req);
        wr = 1'b0; ev = '0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values and idle levels.
        compare_all("R1");
        cyc(12'h008, 0, 0, 0, "R1");
        cyc(12'h00C, 0, 0, 0, "R1");
        cyc(12'h010, 0, 0, 0, "R1");
        // R10: capability word per style.
        cyc(12'h014, 0, 0, 0, "R10");
        // R2: events set status with enables off.
        cyc(12'h010, 0, 0, 4'b0001, "R2");
        cyc(12'h010, 0, 0, 4'b1000, "R2");
        cyc(12'h010, 0, 0, 4'b0110, "R2");
        // R3: write-1 clears, write-0 keeps.
        cyc(12'h010, 1, 32'h0000_0001, 0, "R3");
        cyc(12'h010, 1, 32'h0000_0000, 0, "R3");
        cyc(12'h010, 1, 32'h0000_0080, 0, "R3");
        // R4: set beats clear on the same bit.
        cyc(12'h010, 1, 32'h0000_0002, 4'b0010, "R4");
        cyc(12'h010, 0, 0, 0, "R4");
        // R5: enable register keeps only defined bits; R7/R8 line activity.
        cyc(12'h008, 1, 32'hFFFF_FFFF, 0, "R5");
        cyc(12'h008, 0, 0, 0, "R8");
        cyc(12'h008, 0, 0, 0, "R7");
        cyc(12'h008, 0, 0, 0, "R8");
        // R6: gate off masks line, status kept.
        cyc(12'h008, 1, 32'h0000_0087, 0, "R6");
        cyc(12'h010, 0, 0, 0, "R6");
        cyc(12'h010, 0, 0, 4'b0001, "R6");
        // R8: gate back on gives a new pulse.
        cyc(12'h008, 1, 32'h8000_0087, 0, "R8");
        cyc(12'h008, 0, 0, 0, "R8");
        // Clear everything, then only bit 0 enabled.
        cyc(12'h010, 1, 32'hFFFF_FFFF, 0, "R3");
        cyc(12'h008, 1, 32'h8000_0001, 0, "R5");
        // R7: disabled event raises nothing.
        cyc(12'h010, 0, 0, 4'b0010, "R7");
        cyc(12'h010, 0, 0, 0, "R7");
        cyc(12'h010, 0, 0, 4'b0001, "R7");
        cyc(12'h010, 0, 0, 0, "R8");
        // R8: clear and re-raise produces a second pulse.
        cyc(12'h010, 1, 32'h0000_0001, 0, "R8");
        cyc(12'h010, 0, 0, 4'b0001, "R8");
        cyc(12'h010, 0, 0, 4'b0001, "R8");
        // R9: line number keeps low 8 bits.
        cyc(12'h00C, 1, 32'h1234_56A5, 0, "R9");
        cyc(12'h00C, 1, 32'hFFFF_FF3C, 0, "R9");
        // R10: write to capability word ignored.
        cyc(12'h014, 1, 32'h0000_0000, 0, "R10");
        cyc(12'h014, 1, 32'hFFFF_FFFF, 0, "R10");
        // R11: unmapped offsets read zero and writes change nothing.
        cyc(12'h020, 1, 32'hFFFF_FFFF, 0, "R11");
        cyc(12'h004, 1, 32'hFFFF_FFFF, 0, "R11");
        cyc(12'h008, 0, 0, 0, "R11");
        cyc(12'h00C, 0, 0, 0, "R11");
        cyc(12'h010, 0, 0, 0, "R11");
        // R1: reset in mid-operation returns everything to idle.
        rst_n = 1'b0;
        @(posedge clk);
        m_en = 0; m_st = 0; m_vec = 0; m_prev = 0;
        @(negedge clk);
        rst_n = 1'b1;
        cyc(12'h008, 0, 0, 0, "R1");
        cyc(12'h010, 0, 0, 0, "R1");
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule